// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block sits on the CPU side of the interrupt path. It takes one interrupt request that arbitration has already granted. It holds that request until the instruction in flight signals that it has retired. It then counts out the interrupt sequence, whose length depends on three things: the bus width, the low bit of the vector address, and the low bit of the stack pointer. Some source classes stretch the sequence by one or two cycles.

When the count runs out, the block pulses a handler-start strobe for one cycle. In that same cycle it loads the processor interrupt priority level (IPL) from a rule chosen by the source class:

- A maskable source installs its own level.
- The two non-maskable classes force the top level.
- All other classes leave the IPL as it was.

The total response time is therefore the wait for the instruction plus the sequence length. The sequence length is shown on `seq_len` for as long as the block is busy.

Source class encoding on `req_class`:

| Code | Class |
|------|-------|
| 0 | maskable |
| 1 | software |
| 2 | NMI |
| 3 | watchdog |
| 4 | address match |
| 5 | debug break |
| 6 | single-step |
| 7 | treated as software |

Top module: `irq_accept_seq`

## Requirements
- R1: During and right after synchronous reset (`rst` high), `busy` and `handler_start` are 0 and `ipl` is 0.
- R2: While idle, a high `req_valid` at a clock edge accepts the request, and `busy` is 1 from the next cycle on. The sequence does not start before an edge at which `instr_done` is 1. `handler_start` goes high exactly `seq_len` edges after that edge.
- R3: With `bus8`=0, the base length is 18 plus bit 0 of `vec_addr` plus bit 0 of `sp`. This gives 18, 19 or 20 cycles.
- R4: With `bus8`=1, the base length is 20, whatever the parity of `vec_addr` and `sp`.
- R5: Class 5 (debug break) adds 2 cycles to the base length. Classes 4 (address match) and 6 (single-step) add 1 cycle. All other classes add nothing.
- R6: For class 0 (maskable), `ipl` takes `req_level` as it was at acceptance.
- R7: For class 2 (NMI) and class 3 (watchdog), `ipl` becomes 7.
- R8: For classes 1, 4, 5, 6 and 7, `ipl` keeps its previous value.
- R9: `handler_start` is a single-cycle pulse. `ipl` changes only in that cycle, and `busy` is 0 in the cycle after it.
- R10: A request presented while `busy` is 1 is ignored. `seq_len` stays constant, and the IPL result follows the accepted request.
- R11: A wait of 30 or more cycles for `instr_done` delays the sequence without changing its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Granted interrupt request present |
| req_class | input | 3 | Source class code |
| req_level | input | 3 | Priority level of the request |
| instr_done | input | 1 | Current instruction retires this cycle |
| vec_addr | input | VA_W | Vector address of the request |
| sp | input | SP_W | Current stack pointer |
| bus8 | input | 1 | 1 selects the 8-bit bus, 0 the 16-bit bus |
| busy | output | 1 | Request accepted and not yet finished |
| seq_len | output | 5 | Sequence length of the accepted request |
| ipl | output | 3 | Processor interrupt priority level |
| handler_start | output | 1 | One-cycle strobe marking the handler's first cycle |

## Verification
On every cycle, the assertions check the handshake shape:
- the strobe is one cycle long and appears only while busy;
- `busy` falls right after the strobe;
- `seq_len` is in range and holds steady while busy;
- the IPL outcome matches the latched class at the strobe, and the IPL does not move at any other time.

Only the bench scenarios can show the rest. They show that the exact cycle count from `instr_done` to the strobe matches the parity, bus and class rule. They show that a 30-cycle instruction wait only delays the sequence. They show that a second request during busy leaves the outcome of the first intact.

// File: rtl/irq_accept_seq.sv
module irq_accept_seq #(
  parameter int VA_W       = 20,
  parameter int SP_W       = 16,
  parameter int BASE_CYC   = 18,
  parameter int NARROW_CYC = 20,
  parameter int LEN_W      = $clog2(NARROW_CYC + 3)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [2:0]      req_class,
  input  logic [2:0]      req_level,
  input  logic            instr_done,
  input  logic [VA_W-1:0] vec_addr,
  input  logic [SP_W-1:0] sp,
  input  logic            bus8,
  output logic            busy,
  output logic [LEN_W-1:0] seq_len,
  output logic [2:0]      ipl,
  output logic            handler_start
);

  localparam logic [2:0] C_MASK = 3'd0;
  localparam logic [2:0] C_NMI  = 3'd2;
  localparam logic [2:0] C_WDT  = 3'd3;
  localparam logic [2:0] C_AMAT = 3'd4;
  localparam logic [2:0] C_DBG  = 3'd5;
  localparam logic [2:0] C_STEP = 3'd6;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SEQ, S_DONE} st_t;

  st_t             st;
  logic [LEN_W-1:0] len_d, len_q, cnt;
  logic [2:0]      cls_q, lvl_q;

  always_comb begin
    if (bus8) len_d = LEN_W'(NARROW_CYC);
    else      len_d = LEN_W'(BASE_CYC) + LEN_W'(vec_addr[0]) + LEN_W'(sp[0]);
    case (req_class)
      C_DBG:          len_d = len_d + LEN_W'(2);
      C_AMAT, C_STEP: len_d = len_d + LEN_W'(1);
      default:        ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      ipl   <= '0;
      cnt   <= '0;
      len_q <= '0;
      cls_q <= '0;
      lvl_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          cls_q <= req_class;
          lvl_q <= req_level;
          len_q <= len_d;
          st    <= S_WAIT;
        end
        S_WAIT: if (instr_done) begin
          cnt <= len_q - LEN_W'(1);
          st  <= S_SEQ;
        end
        S_SEQ: if (cnt == '0) begin
          st <= S_DONE;
          if (cls_q == C_MASK)                        ipl <= lvl_q;
          else if (cls_q == C_NMI || cls_q == C_WDT)  ipl <= 3'd7;
        end else begin
          cnt <= cnt - LEN_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy          = (st != S_IDLE);
  assign handler_start = (st == S_DONE);
  assign seq_len       = len_q;

endmodule

// File: rtl/irq_accept_seq_chk.sv
module irq_accept_seq_chk #(
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             handler_start,
  input logic [2:0]       ipl,
  input logic [LEN_W-1:0] seq_len,
  input logic [2:0]       cls,
  input logic [2:0]       lvl
);

  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    handler_start |-> busy); // R9
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    handler_start |=> !handler_start); // R9
  AST_IDLE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    handler_start |=> !busy); // R9
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (seq_len >= 18 && seq_len <= 22)); // R3
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(rst)) |-> $stable(seq_len)); // R10
  AST_MASK_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (handler_start && cls == 3'd0) |-> ipl == lvl); // R6
  AST_NMI_TOP: assert property (@(posedge clk) disable iff (rst)
    (handler_start && (cls == 3'd2 || cls == 3'd3)) |-> ipl == 3'd7); // R7
  AST_IPL_KEPT: assert property (@(posedge clk) disable iff (rst)
    (handler_start && cls != 3'd0 && cls != 3'd2 && cls != 3'd3 && !$past(rst))
      |-> $stable(ipl)); // R8
  AST_IPL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!handler_start && !$past(rst)) |-> $stable(ipl)); // R9

endmodule

bind irq_accept_seq irq_accept_seq_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .handler_start(handler_start),
  .ipl(ipl), .seq_len(seq_len), .cls(cls_q), .lvl(lvl_q)
);

// File: tb/irq_accept_seq_test.sv
module irq_accept_seq_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0;
  logic [2:0]  req_class = 0;
  logic [2:0]  req_level = 0;
  logic        instr_done = 0;
  logic [19:0] vec_addr = 0;
  logic [15:0] sp = 0;
  logic        bus8 = 0;
  logic        busy, handler_start;
  logic [4:0]  seq_len;
  logic [2:0]  ipl;

  int checks = 0;
  int errors = 0;
  logic [2:0] ipl_model = 0;

  always #5 clk = ~clk;

  irq_accept_seq uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
    .req_level(req_level), .instr_done(instr_done), .vec_addr(vec_addr),
    .sp(sp), .bus8(bus8), .busy(busy), .seq_len(seq_len), .ipl(ipl),
    .handler_start(handler_start)
  );

  function automatic int exp_len(logic [2:0] c, logic [19:0] va, logic [15:0] s, logic b8);
    int n;
    n = b8 ? 20 : 18 + int'(va[0]) + int'(s[0]);
    if (c == 5) n += 2;
    else if (c == 4 || c == 6) n += 1;
    return n;
  endfunction

  function automatic logic [2:0] exp_ipl(logic [2:0] c, logic [2:0] l, logic [2:0] prev);
    if (c == 0) return l;
    if (c == 2 || c == 3) return 3'd7;
    return prev;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_one(logic [2:0] c, logic [2:0] l, logic [19:0] va,
                         logic [15:0] s, logic b8, int wait_n, bit intrude);
    int n;
    logic [2:0] want;
    n = exp_len(c, va, s, b8);
    want = exp_ipl(c, l, ipl_model);
    @(negedge clk);
    req_valid = 1; req_class = c; req_level = l; vec_addr = va; sp = s; bus8 = b8;
    @(negedge clk);
    if (intrude) begin
      req_class = 3'd2; req_level = ~l; vec_addr = ~va; sp = ~s; bus8 = ~b8;
    end else req_valid = 0;
    check("R2 busy after accept", int'(busy), 1);
    check(b8 ? "R4 seq_len" : "R3/R5 seq_len", int'(seq_len), n);
    for (int i = 0; i < wait_n; i++) begin
      @(negedge clk);
      if (handler_start || !busy) check("R2/R11 held until instr_done", int'(handler_start), 0);
    end
    req_valid = 0;
    instr_done = 1;
    @(negedge clk);
    instr_done = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i < n) begin
        if (handler_start) check("R2 strobe early", i, n);
      end else begin
        check("R2 strobe timing", int'(handler_start), 1);
        check(c == 0 ? "R6 ipl" : (c == 2 || c == 3) ? "R7 ipl" : "R8 ipl", int'(ipl), int'(want));
        if (intrude) check("R10 seq_len kept", int'(seq_len), n);
      end
    end
    @(negedge clk);
    check("R9 busy drops", int'(busy), 0);
    check("R9 single pulse", int'(handler_start), 0);
    check("R9 ipl held", int'(ipl), int'(want));
    ipl_model = want;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 handler_start", int'(handler_start), 0);
    check("R1 ipl", int'(ipl), 0);
    rst = 0;
    @(negedge clk);
    check("R1 after release", int'(busy), 0);

    run_one(3'd0, 3'd3, 20'h00100, 16'h0400, 1'b0, 0, 0);  // R3 even/even -> 18
    run_one(3'd1, 3'd5, 20'h00101, 16'h0400, 1'b0, 2, 0);  // R3 19, R8
    run_one(3'd0, 3'd5, 20'h00100, 16'h0401, 1'b0, 1, 0);  // R3 19, R6
    run_one(3'd4, 3'd1, 20'h00101, 16'h0401, 1'b0, 0, 0);  // R3 20 + R5 1
    run_one(3'd5, 3'd1, 20'h00101, 16'h0401, 1'b1, 3, 0);  // R4 + R5 debug
    run_one(3'd6, 3'd0, 20'h00100, 16'h0400, 1'b1, 0, 0);  // R4 + R5 step
    run_one(3'd2, 3'd0, 20'h00100, 16'h0400, 1'b0, 30, 0); // R11 30-cycle wait, R7
    run_one(3'd0, 3'd2, 20'h00102, 16'h0403, 1'b0, 31, 0); // R11
    run_one(3'd3, 3'd0, 20'h00103, 16'h0402, 1'b0, 4, 0);  // R7 watchdog
    run_one(3'd0, 3'd1, 20'h00100, 16'h0400, 1'b0, 5, 1);  // R10 intruding NMI
    run_one(3'd7, 3'd6, 20'h00101, 16'h0401, 1'b1, 2, 1);  // R10, R8 class 7

    for (int k = 0; k < 60; k++) begin
      run_one(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
              20'($urandom), 16'($urandom), 1'($urandom_range(0, 1)),
              int'($urandom_range(0, 32)), bit'($urandom_range(0, 1)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule